// File: doc/BRIEF.md
# DMA Channel Interrupt and Control Register Bank

This block is the shared register bank of a multi-channel DMA engine. It sits on a simple word-addressed write/read bus and holds the engine-wide burst options, per-channel freeze and one-shot reset controls, per-channel completion flags with their interrupt enables, and per-channel error flags with an error-type bit. The DMA channels report progress to it through three pulse vectors: command done, termination and bus error. The bank turns these pulses into sticky flags and drives one interrupt line per channel.

Every register is reached at four consecutive word addresses. The first slot replaces the register, the second ORs a mask into it, the third clears the bits of a mask, and the fourth is inert. Software can therefore acknowledge one channel by writing a single-bit mask to the clear slot, without a read-modify-write that could race the hardware. The error register keeps a flag in its lower half and a type bit in its upper half. The type bit is 1 for a bus error and 0 for a termination. A termination that lands together with a done pulse counts as a normal end and raises no error.

Top module: `dma_irq_regbank`

## Requirements
- R1: After reset, every register reads 0 and all outputs (irq, freeze, channel reset, burst enables) are 0.
- R2: The bus word address is {register index[5:2], slot[1:0]}. Index 0 is the config register, 1 the completion register, 2 the error register and 3 the channel-control register. A write to slot 0 replaces the register's whole value, and reads of slots 0 to 2 return the register.
- R3: A write to slot 1 ORs the write data into the register.
- R4: A write to slot 2 clears every register bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A done pulse on channel n sets completion flag n (bit n of register 1) at the next clock edge. Bit 16+n of register 1 is the interrupt enable of channel n.
- R6: A bus-error pulse on channel n sets error flag n (bit n of register 2) and error-type bit 16+n to 1.
- R7: A termination pulse on channel n without a done pulse sets error flag n and clears type bit 16+n. A termination pulse that arrives with a done pulse only sets completion flag n.
- R8: irq_o[n] is high exactly when (completion flag n AND enable n) OR error flag n.
- R9: If an event pulse and a bus write that clears the same flag fall in the same cycle, the flag ends set.
- R10: Bits 31:16 of register 3 are per-channel reset requests. A request that has been set reads back and drives chan_rst_o for exactly one cycle, then clears by itself, even if a write tries to keep it set.
- R11: Bits 15:0 of register 3 drive freeze_o. Config bit 28 drives burst_en_o and config bit 29 drives burst8_en_o.
- R12: The other config bits read 0. Writes to slot 3 or to register indexes above 3 change nothing, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 6 | Word address: register index and slot |
| bus_wdata | input | 32 | Write data or mask |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| done_ev | input | 16 | Per-channel command-done pulses |
| term_ev | input | 16 | Per-channel termination pulses |
| berr_ev | input | 16 | Per-channel bus-error pulses |
| irq_o | output | 16 | Per-channel interrupt lines |
| freeze_o | output | 16 | Per-channel freeze controls |
| chan_rst_o | output | 16 | Per-channel one-cycle reset pulses |
| burst_en_o | output | 1 | Burst enable |
| burst8_en_o | output | 1 | 8-beat burst enable |

## Verification
The assertions assume that each event input is sampled as a level on every clock, so an input held high for several cycles counts as repeated events. They also assume that a bus write and an event in the same cycle both belong to that clock edge. These assumptions are what allow the event-over-clear rule and the one-cycle reset pulse to be checked without tracking the bus. The stimulus changes all inputs only on the falling edge. Its directed phase sets up both kinds of coincidence on purpose: a termination together with a done pulse, and a clear together with an event. Its random phase draws sparse, overlapping event vectors together with writes and reads at legal, inert and unmapped addresses.

// File: rtl/dma_irq_regs_pkg.sv
`timescale 1ns/1ps
package dma_irq_regs_pkg;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = 16;
  localparam int NUM_REGS = 4;

  // register indexes (address bits above the slot field)
  localparam int IDX_CFG = 0;
  localparam int IDX_CMP = 1;
  localparam int IDX_ERR = 2;
  localparam int IDX_CHC = 3;

  // config bit positions
  localparam int BURST_BIT  = 28;
  localparam int BURST8_BIT = 29;

  typedef enum logic [1:0] {
    ACC_WR   = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2,
    ACC_NONE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/dma_irq_regs_dec.sv
`timescale 1ns/1ps
module dma_irq_regs_dec
  import dma_irq_regs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [NUM_REGS-1:0] reg_we,
  output logic [WORD_W-1:0]   keep_m,
  output logic [WORD_W-1:0]   or_m
);
  localparam int IDX_W = ADDR_W - 2;

  acc_kind_e        slot;
  logic [IDX_W-1:0] idx;

  assign slot = acc_kind_e'(bus_addr[1:0]);
  assign idx  = bus_addr[ADDR_W-1:2];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      reg_we[i] = bus_wr && (slot != ACC_NONE) && (idx == IDX_W'(i));
    end
  end

  // new value = (old & keep_m) | or_m
  always_comb begin
    keep_m = '1;
    or_m   = '0;
    unique case (slot)
      ACC_WR:  begin keep_m = '0;         or_m = bus_wdata; end
      ACC_SET: begin keep_m = '1;         or_m = bus_wdata; end
      ACC_CLR: begin keep_m = ~bus_wdata; or_m = '0;        end
      default: begin keep_m = '1;         or_m = '0;        end
    endcase
  end
endmodule

// File: rtl/dma_irq_chan_cell.sv
`timescale 1ns/1ps
module dma_irq_chan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_we,
  input  logic cmp_flag_w,
  input  logic cmp_en_w,
  input  logic err_we,
  input  logic err_flag_w,
  input  logic err_type_w,
  input  logic done_ev,
  input  logic term_ev,
  input  logic berr_ev,
  output logic cmp_flag,
  output logic cmp_en,
  output logic err_flag,
  output logic err_type,
  output logic irq
);
  logic cmp_flag_q, cmp_flag_d;
  logic cmp_en_q,   cmp_en_d;
  logic err_flag_q, err_flag_d;
  logic err_type_q, err_type_d;
  logic is_err, cmp_ce, err_ce;

  // a termination that comes with a done pulse is a normal end
  assign is_err = berr_ev | (term_ev & ~done_ev);
  assign cmp_ce = cmp_we | done_ev;
  assign err_ce = err_we | is_err;

  always_comb begin
    cmp_flag_d = cmp_flag_q;
    cmp_en_d   = cmp_en_q;
    if (cmp_we) begin
      cmp_flag_d = cmp_flag_w;
      cmp_en_d   = cmp_en_w;
    end
    if (done_ev) begin
      cmp_flag_d = 1'b1;
    end
  end

  always_comb begin
    err_flag_d = err_flag_q;
    err_type_d = err_type_q;
    if (err_we) begin
      err_flag_d = err_flag_w;
      err_type_d = err_type_w;
    end
    if (is_err) begin
      err_flag_d = 1'b1;
      err_type_d = berr_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_flag_q <= 1'b0;
      cmp_en_q   <= 1'b0;
    end else if (cmp_ce) begin
      cmp_flag_q <= cmp_flag_d;
      cmp_en_q   <= cmp_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_flag_q <= 1'b0;
      err_type_q <= 1'b0;
    end else if (err_ce) begin
      err_flag_q <= err_flag_d;
      err_type_q <= err_type_d;
    end
  end

  assign cmp_flag = cmp_flag_q;
  assign cmp_en   = cmp_en_q;
  assign err_flag = err_flag_q;
  assign err_type = err_type_q;
  assign irq      = (cmp_flag_q & cmp_en_q) | err_flag_q;
endmodule

// File: rtl/dma_irq_ctl.sv
`timescale 1ns/1ps
module dma_irq_ctl #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_w,
  input  logic              chc_we,
  input  logic [NUM_CH-1:0] frz_w,
  input  logic [NUM_CH-1:0] rst_w,
  output logic              burst_en,
  output logic              burst8_en,
  output logic [NUM_CH-1:0] frz,
  output logic [NUM_CH-1:0] rst_req
);
  logic [1:0]        cfg_q, cfg_d;
  logic [NUM_CH-1:0] frz_q, frz_d;
  logic [NUM_CH-1:0] rst_q, rst_d;
  logic              rst_ce;

  always_comb begin
    cfg_d = cfg_we ? cfg_w : cfg_q;
    frz_d = chc_we ? frz_w : frz_q;
    // a request that is high now always drops at the next edge
    rst_d = (chc_we ? rst_w : '0) & ~rst_q;
  end

  assign rst_ce = chc_we | (|rst_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= '0;
    end else if (chc_we) begin
      frz_q <= frz_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= '0;
    end else if (rst_ce) begin
      rst_q <= rst_d;
    end
  end

  assign burst_en  = cfg_q[0];
  assign burst8_en = cfg_q[1];
  assign frz       = frz_q;
  assign rst_req   = rst_q;
endmodule

// File: rtl/dma_irq_regbank.sv
`timescale 1ns/1ps
module dma_irq_regbank
  import dma_irq_regs_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_CH-1:0] done_ev,
  input  logic [NUM_CH-1:0] term_ev,
  input  logic [NUM_CH-1:0] berr_ev,
  output logic [NUM_CH-1:0] irq_o,
  output logic [NUM_CH-1:0] freeze_o,
  output logic [NUM_CH-1:0] chan_rst_o,
  output logic              burst_en_o,
  output logic              burst8_en_o
);
  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NUM_REGS-1:0] reg_we;
  logic [WORD_W-1:0]   keep_m, or_m;

  dma_irq_regs_dec #(.ADDR_W(ADDR_W)) dec_i (
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .reg_we    (reg_we),
    .keep_m    (keep_m),
    .or_m      (or_m)
  );

  logic [NUM_CH-1:0] cmp_flag, cmp_en, err_flag, err_type;
  logic [NUM_CH-1:0] frz, rst_req;
  logic              burst_en, burst8_en;
  logic [WORD_W-1:0] cur_cfg, cur_cmp, cur_err, cur_chc;
  logic [WORD_W-1:0] new_cfg, new_cmp, new_err, new_chc;

  always_comb begin
    cur_cfg = '0;
    cur_cfg[BURST_BIT]  = burst_en;
    cur_cfg[BURST8_BIT] = burst8_en;
    cur_cmp = '0;
    cur_cmp[NUM_CH-1:0]      = cmp_flag;
    cur_cmp[HALF_W+:NUM_CH]  = cmp_en;
    cur_err = '0;
    cur_err[NUM_CH-1:0]      = err_flag;
    cur_err[HALF_W+:NUM_CH]  = err_type;
    cur_chc = '0;
    cur_chc[NUM_CH-1:0]      = frz;
    cur_chc[HALF_W+:NUM_CH]  = rst_req;
  end

  assign new_cfg = (cur_cfg & keep_m) | or_m;
  assign new_cmp = (cur_cmp & keep_m) | or_m;
  assign new_err = (cur_err & keep_m) | or_m;
  assign new_chc = (cur_chc & keep_m) | or_m;

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      dma_irq_chan_cell cell_i (
        .clk        (clk),
        .rst_n      (rst_sync_n),
        .cmp_we     (reg_we[IDX_CMP]),
        .cmp_flag_w (new_cmp[n]),
        .cmp_en_w   (new_cmp[HALF_W+n]),
        .err_we     (reg_we[IDX_ERR]),
        .err_flag_w (new_err[n]),
        .err_type_w (new_err[HALF_W+n]),
        .done_ev    (done_ev[n]),
        .term_ev    (term_ev[n]),
        .berr_ev    (berr_ev[n]),
        .cmp_flag   (cmp_flag[n]),
        .cmp_en     (cmp_en[n]),
        .err_flag   (err_flag[n]),
        .err_type   (err_type[n]),
        .irq        (irq_o[n])
      );
    end
  endgenerate

  dma_irq_ctl #(.NUM_CH(NUM_CH)) ctl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cfg_we    (reg_we[IDX_CFG]),
    .cfg_w     ({new_cfg[BURST8_BIT], new_cfg[BURST_BIT]}),
    .chc_we    (reg_we[IDX_CHC]),
    .frz_w     (new_chc[NUM_CH-1:0]),
    .rst_w     (new_chc[HALF_W+:NUM_CH]),
    .burst_en  (burst_en),
    .burst8_en (burst8_en),
    .frz       (frz),
    .rst_req   (rst_req)
  );

  // read path: slots 0..2 return the register, slot 3 and unmapped return 0
  always_comb begin
    bus_rdata = '0;
    if (acc_kind_e'(bus_addr[1:0]) != ACC_NONE) begin
      case (bus_addr[ADDR_W-1:2])
        IDX_W'(IDX_CFG): bus_rdata = cur_cfg;
        IDX_W'(IDX_CMP): bus_rdata = cur_cmp;
        IDX_W'(IDX_ERR): bus_rdata = cur_err;
        IDX_W'(IDX_CHC): bus_rdata = cur_chc;
        default:         bus_rdata = '0;
      endcase
    end
  end

  assign freeze_o    = frz;
  assign chan_rst_o  = rst_req;
  assign burst_en_o  = burst_en;
  assign burst8_en_o = burst8_en;
endmodule

// File: rtl/dma_irq_regbank_chk.sv
`timescale 1ns/1ps
module dma_irq_regbank_chk #(
  parameter int NUM_CH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] done_ev,
  input logic [NUM_CH-1:0] term_ev,
  input logic [NUM_CH-1:0] berr_ev,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] chan_rst_o,
  input logic [NUM_CH-1:0] cmp_flag,
  input logic [NUM_CH-1:0] cmp_en,
  input logic [NUM_CH-1:0] err_flag,
  input logic [NUM_CH-1:0] err_type
);
  // R5 and R9: a done pulse always leaves its flag set, even against a clear
  p_done_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_ev) |=> ((cmp_flag & $past(done_ev)) == $past(done_ev)));

  p_berr_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|berr_ev) |=> ((err_flag & err_type & $past(berr_ev)) == $past(berr_ev)));

  p_term_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(term_ev & ~done_ev & ~berr_ev)) |=>
      ((err_flag & ~err_type & $past(term_ev & ~done_ev & ~berr_ev))
        == $past(term_ev & ~done_ev & ~berr_ev)));

  p_berr_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|berr_ev) |=> ((irq_o & $past(berr_ev)) == $past(berr_ev)));

  p_done_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_ev) |=> ((irq_o & $past(done_ev) & cmp_en) == ($past(done_ev) & cmp_en)));

  p_rst_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|chan_rst_o) |=> ((chan_rst_o & $past(chan_rst_o)) == '0));
endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(.NUM_CH(NUM_CH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .done_ev    (done_ev),
  .term_ev    (term_ev),
  .berr_ev    (berr_ev),
  .irq_o      (irq_o),
  .chan_rst_o (chan_rst_o),
  .cmp_flag   (cmp_flag),
  .cmp_en     (cmp_en),
  .err_flag   (err_flag),
  .err_type   (err_type)
);

// File: tb/dma_irq_regbank_tb.sv
`timescale 1ns/1ps
module dma_irq_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] done_ev, term_ev, berr_ev;
  logic [15:0] irq_o, freeze_o, chan_rst_o;
  logic        burst_en_o, burst8_en_o;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned cycles = 0;
  bit          finished = 0;

  // reference state
  logic [31:0] m_cfg, m_cmp, m_err, m_chc;

  always #10 clk = ~clk;

  dma_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_ev(done_ev),
    .term_ev(term_ev), .berr_ev(berr_ev), .irq_o(irq_o), .freeze_o(freeze_o),
    .chan_rst_o(chan_rst_o), .burst_en_o(burst_en_o), .burst8_en_o(burst8_en_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_alias(logic [1:0] slot, logic [31:0] cur, logic [31:0] w);
    case (slot)
      2'd0:    return w;
      2'd1:    return cur | w;
      2'd2:    return cur & ~w;
      default: return cur;
    endcase
  endfunction

  function automatic logic [31:0] m_read(logic [5:0] a);
    if (a[1:0] == 2'd3) return 32'h0;
    case (a[5:2])
      4'd0:    return m_cfg;
      4'd1:    return m_cmp;
      4'd2:    return m_err;
      4'd3:    return m_chc;
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_step();
    logic [15:0] old_rst;
    logic [15:0] wr_rst;
    logic [31:0] nv;
    old_rst = m_chc[31:16];
    wr_rst  = 16'h0;
    if (bus_wr && bus_addr[1:0] != 2'd3) begin
      case (bus_addr[5:2])
        4'd0: m_cfg = m_alias(bus_addr[1:0], m_cfg, bus_wdata) & 32'h3000_0000;
        4'd1: m_cmp = m_alias(bus_addr[1:0], m_cmp, bus_wdata);
        4'd2: m_err = m_alias(bus_addr[1:0], m_err, bus_wdata);
        4'd3: begin
          nv = m_alias(bus_addr[1:0], m_chc, bus_wdata);
          m_chc[15:0] = nv[15:0];
          wr_rst = nv[31:16];
        end
        default: ;
      endcase
    end
    m_chc[31:16] = wr_rst & ~old_rst;
    for (int n = 0; n < 16; n++) begin
      if (done_ev[n]) m_cmp[n] = 1'b1;
      if (berr_ev[n] || (term_ev[n] && !done_ev[n])) begin
        m_err[n]    = 1'b1;
        m_err[16+n] = berr_ev[n];
      end
    end
  endtask

  task automatic compare_outs();
    chk("R8 irq_o", {16'h0, irq_o}, {16'h0, (m_cmp[15:0] & m_cmp[31:16]) | m_err[15:0]});
    chk("R11 freeze_o", {16'h0, freeze_o}, {16'h0, m_chc[15:0]});
    chk("R10 chan_rst_o", {16'h0, chan_rst_o}, {16'h0, m_chc[31:16]});
    chk("R11 burst", {30'h0, burst8_en_o, burst_en_o}, {30'h0, m_cfg[29], m_cfg[28]});
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_outs();
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd_lit(string tag, logic [5:0] a, logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic rd_mdl(string tag, logic [5:0] a);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, m_read(a));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      $display("FAIL R1 watchdog act=%0d exp<=20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    m_cfg = 0; m_cmp = 0; m_err = 0; m_chc = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 6'h0; bus_wdata = 32'h0;
    done_ev = 16'h0; term_ev = 16'h0; berr_ev = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R1: reset state
    rd_lit("R1 cfg after reset", 6'h00, 32'h0);
    rd_lit("R1 cmp after reset", 6'h04, 32'h0);
    rd_lit("R1 err after reset", 6'h08, 32'h0);
    rd_lit("R1 chc after reset", 6'h0C, 32'h0);
    chk("R1 irq after reset", {16'h0, irq_o}, 32'h0);

    // R12 / R2: config keeps only burst bits; base write replaces
    wr(6'h00, 32'hFFFF_FFFF);
    rd_lit("R12 cfg unused bits", 6'h00, 32'h3000_0000);
    chk("R11 burst both on", {30'h0, burst8_en_o, burst_en_o}, 32'h3);
    wr(6'h00, 32'h1000_0000);
    rd_lit("R2 cfg replace", 6'h00, 32'h1000_0000);

    // R3 set alias, R4 clear alias on completion enables
    wr(6'h05, 32'h00F0_0000);
    wr(6'h05, 32'h0001_0000);
    rd_lit("R3 cmp set alias", 6'h04, 32'h00F1_0000);
    wr(6'h06, 32'h0030_0000);
    rd_lit("R4 cmp clear alias", 6'h04, 32'h00C1_0000);
    rd_lit("R2 read via set slot", 6'h05, 32'h00C1_0000);

    // R5: done pulses on channels 0 and 15
    done_ev = 16'h8001;
    cyc();
    done_ev = 16'h0;
    rd_lit("R5 done flags", 6'h04, 32'h00C1_8001);
    chk("R8 irq enabled ch0 only", {16'h0, irq_o}, 32'h0000_0001);

    // R9: clear of ch0 and ch6 while ch6 done pulses
    bus_wr = 1'b1; bus_addr = 6'h06; bus_wdata = 32'h0000_0041; done_ev = 16'h0040;
    cyc();
    bus_wr = 1'b0; done_ev = 16'h0;
    rd_lit("R9 event beats clear", 6'h04, 32'h00C1_8040);
    chk("R8 irq ch6 enabled", {16'h0, irq_o}, 32'h0000_0040);

    // R6: bus error on channel 7
    berr_ev = 16'h0080;
    cyc();
    berr_ev = 16'h0;
    rd_lit("R6 bus error type", 6'h08, 32'h0080_0080);
    chk("R8 irq from error", {16'h0, irq_o}, 32'h0000_00C0);

    // R7: termination alone, then termination with done
    term_ev = 16'h0004;
    cyc();
    term_ev = 16'h0;
    rd_lit("R7 termination error", 6'h08, 32'h0080_0084);
    term_ev = 16'h0200; done_ev = 16'h0200;
    cyc();
    term_ev = 16'h0; done_ev = 16'h0;
    rd_lit("R7 term+done no error", 6'h08, 32'h0080_0084);
    rd_lit("R7 term+done completes", 6'h04, 32'h00C1_8240);

    // R4 on error register: clear only flag 7
    wr(6'h0A, 32'h0000_0080);
    rd_lit("R4 err clear flag", 6'h08, 32'h0080_0004);

    // R11 freeze
    wr(6'h0C, 32'h0000_00F0);
    chk("R11 freeze value", {16'h0, freeze_o}, 32'h0000_00F0);

    // R10 one-shot reset of channel 5, retried while high
    wr(6'h0D, 32'h0020_0000);
    chk("R10 reset pulse high", {16'h0, chan_rst_o}, 32'h0000_0020);
    rd_lit("R10 reset reads 1", 6'h0C, 32'h0020_00F0);
    wr(6'h0D, 32'h0020_0000);
    chk("R10 reset self clears", {16'h0, chan_rst_o}, 32'h0);
    rd_lit("R10 reset reads 0", 6'h0C, 32'h0000_00F0);

    // R12 inert slot and unmapped index
    wr(6'h07, 32'hFFFF_FFFF);
    rd_lit("R12 slot3 write ignored", 6'h04, 32'h00C1_8240);
    rd_lit("R12 slot3 reads 0", 6'h07, 32'h0);
    wr(6'h10, 32'hFFFF_FFFF);
    rd_lit("R12 unmapped reads 0", 6'h10, 32'h0);

    // random phase
    for (int i = 0; i < 600; i++) begin
      done_ev = 16'($urandom & $urandom);
      term_ev = 16'($urandom & $urandom);
      berr_ev = 16'($urandom & $urandom & $urandom);
      bus_wr  = ($urandom % 3) == 0;
      bus_addr = 6'($urandom % 20);
      bus_wdata = $urandom;
      cyc();
      bus_wr = 1'b0;
      rd_mdl("R2 random readback", 6'($urandom % 20));
    end
    done_ev = 16'h0; term_ev = 16'h0; berr_ev = 16'h0;
    cyc();
    finish_run();
  end
endmodule